// File: doc/BRIEF.md
# Bus Error Reporting Controller

This block sits beside the PCI master side of a host bridge. It collects two kinds of failed transaction and one external alarm, then reports them to the host processor. The two failures are a master-abort (no target claimed the cycle) and a target-abort (the target refused the cycle). The alarm is a level-sensitive non-maskable interrupt from an outside agent. Each abort is latched into a sticky flag of a 16-bit PCI status word, and software clears that flag by writing a one to its bit.

Reporting to the processor goes through two registered lines: a machine-check request and a transfer-error-acknowledge. An abort is reported on both lines only when its own enable bit and the global machine-check enable are both set. The interrupt input raises machine check alone, follows its level, and leaves the status word untouched. The agent that drives the interrupt keeps its own flag and holds the line until software clears that flag.

Top module: `bus_err_report`

## Requirements
- R1: A cycle with `tabort_evt` high sets status bit 12 from the next clock edge, whatever the enable inputs are.
- R2: A cycle with `mabort_evt` high sets status bit 13 from the next clock edge, whatever the enable inputs are.
- R3: A target-abort with `err_en[7]` and `mc_en` both high drives `mcp_o` and `tea_o` high in the next cycle only, as a one-cycle pulse.
- R4: A master-abort with `err_en[1]` and `mc_en` both high drives `mcp_o` and `tea_o` high in the next cycle only, as a one-cycle pulse.
- R5: An abort whose own enable bit (bit 1 for master-abort, bit 7 for target-abort) is low raises neither output, even if the other abort's enable bit is high.
- R6: While `mc_en` is low, neither output rises, and the status flags still set on aborts.
- R7: With `mc_en` high, `mcp_o` follows `nmi_in` one cycle late for as long as it is held. `tea_o` stays low and no status bit changes.
- R8: Flags are sticky. A cycle with `sts_wr_en` high clears every flag whose bit in `sts_wr_data` is 1. Bits written 0 are left as they were.
- R9: If an abort and a write-one-to-clear of the same flag fall in the same cycle, the flag stays set.
- R10: Synchronous reset clears every status bit and drives `mcp_o` and `tea_o` low. Status bits other than 12 and 13 always read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mabort_evt | input | 1 | One-cycle strobe: a bridge-started PCI transaction ended in master-abort |
| tabort_evt | input | 1 | One-cycle strobe: a bridge-started PCI transaction ended in target-abort |
| nmi_in | input | 1 | Level non-maskable interrupt from an external agent |
| mc_en | input | 1 | Global machine-check reporting enable |
| err_en | input | 8 | Per-error enables; bit 1 gates master-abort, bit 7 gates target-abort |
| sts_wr_en | input | 1 | Status write strobe (write-one-to-clear) |
| sts_wr_data | input | 16 | Status write data; a 1 clears the matching flag |
| sts_flags | output | 16 | PCI status word; bit 13 master-abort flag, bit 12 target-abort flag |
| mcp_o | output | 1 | Machine-check request to the processor, active high |
| tea_o | output | 1 | Transfer-error-acknowledge to the processor, active high |

## Verification
The hardest case to reach from the ports is a software clear that lands in the same cycle as a fresh abort on the same flag. Only that collision shows whether set takes priority over clear. The stimulus first sets the flag, then drives the abort strobe and the clearing write together on one falling edge. It also repeats the collision with the abort on the other flag, so a clear that leaks across flags shows up. All 64 combinations of global enable, both per-error enables, both aborts and the interrupt are swept from a clean state. In every combination the bench checks the pulse cycle, the following cycle and the flags.

// File: rtl/bus_err_pkg.sv
package bus_err_pkg;

  // Abort strobes carried together from the top into the reporting gate.
  typedef struct packed {
    logic master;
    logic target;
  } abort_evt_t;

  // Build a one-hot mask of a given width with bit `pos` set.
  function automatic logic [31:0] bit_mask(input int pos);
    logic [31:0] m;
    m = '0;
    m[pos] = 1'b1;
    return m;
  endfunction

endpackage

// File: rtl/err_flag_bank.sv
module err_flag_bank #(
  parameter int              W         = 16,
  parameter logic [W-1:0]    FLAG_MASK = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set_vec,
  input  logic         clr_en,
  input  logic [W-1:0] clr_vec,
  output logic [W-1:0] flags
);

  // Bits outside FLAG_MASK have no storage; fold them away for lint.
  logic unused_bank_bits;
  assign unused_bank_bits = ^{set_vec & ~FLAG_MASK, clr_vec & ~FLAG_MASK};

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (FLAG_MASK[i]) begin : g_flag
      logic q;

      // Set has priority over a same-cycle clear.
      always_ff @(posedge clk) begin
        if (rst)                          q <= 1'b0;
        else if (set_vec[i])              q <= 1'b1;
        else if (clr_en && clr_vec[i])    q <= 1'b0;
      end

      assign flags[i] = q;

      AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        (flags[i] && !(clr_en && clr_vec[i])) |=> flags[i]); // R8
      AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (rst)
        set_vec[i] |=> flags[i]); // R9
      AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (rst)
        (clr_en && clr_vec[i] && !set_vec[i]) |=> !flags[i]); // R8
    end else begin : g_zero
      assign flags[i] = 1'b0;
    end
  end

endmodule

// File: rtl/err_report_gate.sv
module err_report_gate
  import bus_err_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  abort_evt_t evt,
  input  logic       ma_en,
  input  logic       ta_en,
  input  logic       mc_en,
  input  logic       nmi,
  output logic       mcp,
  output logic       tea
);

  logic abort_rpt;
  logic nmi_rpt;
  logic mcp_q;
  logic tea_q;

  assign abort_rpt = mc_en && ((evt.master && ma_en) || (evt.target && ta_en));
  assign nmi_rpt   = mc_en && nmi;

  // One register stage: minimum latency of a single cycle.
  always_ff @(posedge clk) begin
    if (rst) begin
      mcp_q <= 1'b0;
      tea_q <= 1'b0;
    end else begin
      tea_q <= abort_rpt;
      mcp_q <= abort_rpt || nmi_rpt;
    end
  end

  assign mcp = mcp_q;
  assign tea = tea_q;

  AST_GLOBAL_GATE: assert property (@(posedge clk) disable iff (rst)
    !mc_en |=> (!tea && !mcp)); // R6
  AST_TEA_WITH_MCP: assert property (@(posedge clk) disable iff (rst)
    tea |-> mcp); // R3
  AST_TA_REPORT: assert property (@(posedge clk) disable iff (rst)
    (evt.target && ta_en && mc_en) |=> (tea && mcp)); // R3
  AST_MA_REPORT: assert property (@(posedge clk) disable iff (rst)
    (evt.master && ma_en && mc_en) |=> (tea && mcp)); // R4
  AST_NMI_MCP: assert property (@(posedge clk) disable iff (rst)
    (nmi && mc_en) |=> mcp); // R7
  AST_NMI_NO_TEA: assert property (@(posedge clk) disable iff (rst)
    (!evt.master && !evt.target) |=> !tea); // R7

endmodule

// File: rtl/bus_err_report.sv
module bus_err_report
  import bus_err_pkg::*;
#(
  parameter int STS_W       = 16,
  parameter int MA_FLAG_BIT = 13,
  parameter int TA_FLAG_BIT = 12,
  parameter int EN_W        = 8,
  parameter int MA_EN_BIT   = 1,
  parameter int TA_EN_BIT   = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mabort_evt,
  input  logic             tabort_evt,
  input  logic             nmi_in,
  input  logic             mc_en,
  input  logic [EN_W-1:0]  err_en,
  input  logic             sts_wr_en,
  input  logic [STS_W-1:0] sts_wr_data,
  output logic [STS_W-1:0] sts_flags,
  output logic             mcp_o,
  output logic             tea_o
);

  localparam logic [STS_W-1:0] FLAG_MASK =
    STS_W'(bit_mask(MA_FLAG_BIT) | bit_mask(TA_FLAG_BIT));

  abort_evt_t       evt;
  logic [STS_W-1:0] set_vec;

  logic unused_en_bits;
  assign unused_en_bits = ^err_en;

  assign evt.master = mabort_evt;
  assign evt.target = tabort_evt;

  always_comb begin
    set_vec              = '0;
    set_vec[MA_FLAG_BIT] = mabort_evt;
    set_vec[TA_FLAG_BIT] = tabort_evt;
  end

  err_flag_bank #(
    .W         (STS_W),
    .FLAG_MASK (FLAG_MASK)
  ) flags_i (
    .clk     (clk),
    .rst     (rst),
    .set_vec (set_vec),
    .clr_en  (sts_wr_en),
    .clr_vec (sts_wr_data),
    .flags   (sts_flags)
  );

  err_report_gate gate_i (
    .clk   (clk),
    .rst   (rst),
    .evt   (evt),
    .ma_en (err_en[MA_EN_BIT]),
    .ta_en (err_en[TA_EN_BIT]),
    .mc_en (mc_en),
    .nmi   (nmi_in),
    .mcp   (mcp_o),
    .tea   (tea_o)
  );

  AST_TA_FLAG: assert property (@(posedge clk) disable iff (rst)
    tabort_evt |=> sts_flags[TA_FLAG_BIT]); // R1
  AST_MA_FLAG: assert property (@(posedge clk) disable iff (rst)
    mabort_evt |=> sts_flags[MA_FLAG_BIT]); // R2
  AST_OWN_ENABLE: assert property (@(posedge clk) disable iff (rst)
    (!(mabort_evt && err_en[MA_EN_BIT]) && !(tabort_evt && err_en[TA_EN_BIT]))
      |=> !tea_o); // R5
  AST_NMI_NO_FLAG: assert property (@(posedge clk) disable iff (rst)
    (nmi_in && !mabort_evt && !tabort_evt && !sts_wr_en && sts_flags == '0)
      |=> sts_flags == '0); // R7
  AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (rst)
    (sts_flags & ~FLAG_MASK) == '0); // R10

endmodule

// File: tb/bus_err_report_tb.sv
module bus_err_report_tb_top;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        mabort_evt, tabort_evt, nmi_in, mc_en, sts_wr_en;
  logic [7:0]  err_en;
  logic [15:0] sts_wr_data;
  logic [15:0] sts_flags;
  logic        mcp_o, tea_o;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_err_report dut_i (
    .clk(clk), .rst(rst), .mabort_evt(mabort_evt), .tabort_evt(tabort_evt),
    .nmi_in(nmi_in), .mc_en(mc_en), .err_en(err_en), .sts_wr_en(sts_wr_en),
    .sts_wr_data(sts_wr_data), .sts_flags(sts_flags), .mcp_o(mcp_o), .tea_o(tea_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic idle();
    mabort_evt = 0; tabort_evt = 0; nmi_in = 0; sts_wr_en = 0; sts_wr_data = '0;
  endtask

  task automatic clear_all();
    @(negedge clk); idle(); sts_wr_en = 1; sts_wr_data = 16'hFFFF;
    @(negedge clk); idle();
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog act=hung exp=done");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    idle(); mc_en = 0; err_en = '0; rst = 1;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R10 reset flags", 32'(sts_flags), 32'h0);
    chk("R10 reset mcp", 32'(mcp_o), 32'h0);
    chk("R10 reset tea", 32'(tea_o), 32'h0);

    // Sweep: mc_en, err_en[1], err_en[7], master-abort, target-abort, nmi.
    for (int c = 0; c < 64; c++) begin
      logic mc, e1, e7, ma, ta, nm, rpt;
      logic [15:0] exp_f;
      mc = c[0]; e1 = c[1]; e7 = c[2]; ma = c[3]; ta = c[4]; nm = c[5];
      rpt = mc & ((ma & e1) | (ta & e7));
      exp_f = {2'b00, ma, ta, 12'h000};
      @(negedge clk);
      mc_en = mc; err_en = '0; err_en[1] = e1; err_en[7] = e7;
      mabort_evt = ma; tabort_evt = ta; nmi_in = nm;
      @(negedge clk);
      chk("R3 R4 R5 R6 tea pulse", 32'(tea_o), 32'(rpt));
      chk("R3 R4 R6 R7 mcp", 32'(mcp_o), 32'(rpt | (mc & nm)));
      chk("R1 R2 R6 R7 flags", 32'(sts_flags), 32'(exp_f));
      idle();
      @(negedge clk);
      chk("R3 R4 single-cycle tea", 32'(tea_o), 32'h0);
      chk("R3 R4 R7 mcp drops", 32'(mcp_o), 32'h0);
      chk("R8 sticky flags", 32'(sts_flags), 32'(exp_f));
      clear_all();
      chk("R8 clear all", 32'(sts_flags), 32'h0);
    end

    // R7: long NMI level.
    @(negedge clk); mc_en = 1; err_en = 8'hFF; nmi_in = 1;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      chk("R7 mcp follows nmi", 32'(mcp_o), 32'h1);
      chk("R7 no tea on nmi", 32'(tea_o), 32'h0);
      chk("R7 no flag on nmi", 32'(sts_flags), 32'h0);
    end
    nmi_in = 0;
    @(negedge clk);
    chk("R7 mcp released", 32'(mcp_o), 32'h0);

    // R8: selective write-one-to-clear.
    mc_en = 0; mabort_evt = 1; tabort_evt = 1;
    @(negedge clk); idle();
    chk("R1 R2 both set", 32'(sts_flags), 32'h3000);
    sts_wr_en = 1; sts_wr_data = 16'h1000;
    @(negedge clk); idle();
    chk("R8 clear bit12 only", 32'(sts_flags), 32'h2000);
    sts_wr_en = 1; sts_wr_data = 16'h0000;
    @(negedge clk); idle();
    chk("R8 write zero no effect", 32'(sts_flags), 32'h2000);
    sts_wr_en = 1; sts_wr_data = 16'hDFFF;
    @(negedge clk); idle();
    chk("R8 other ones leave bit13", 32'(sts_flags), 32'h2000);
    sts_wr_data = 16'h2000;
    @(negedge clk);
    chk("R8 data without strobe", 32'(sts_flags), 32'h2000);
    sts_wr_en = 1;
    @(negedge clk); idle();
    chk("R8 clear bit13", 32'(sts_flags), 32'h0000);

    // R9: set beats clear on the same flag; clear of the other flag still works.
    tabort_evt = 1;
    @(negedge clk); idle();
    tabort_evt = 1; sts_wr_en = 1; sts_wr_data = 16'h1000;
    @(negedge clk); idle();
    chk("R9 target set wins", 32'(sts_flags), 32'h1000);
    mabort_evt = 1; sts_wr_en = 1; sts_wr_data = 16'h3000;
    @(negedge clk); idle();
    chk("R9 master set wins, target cleared", 32'(sts_flags), 32'h2000);

    // R10: reset while flags set and NMI reported.
    mc_en = 1; nmi_in = 1; tabort_evt = 1;
    @(negedge clk); tabort_evt = 0;
    chk("R7 mcp before reset", 32'(mcp_o), 32'h1);
    rst = 1;
    @(negedge clk);
    chk("R10 reset clears flags", 32'(sts_flags), 32'h0);
    chk("R10 reset clears mcp", 32'(mcp_o), 32'h0);
    chk("R10 reset clears tea", 32'(tea_o), 32'h0);
    rst = 0; idle();
    @(negedge clk);

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule